// File: doc/BRIEF.md
# Signature hit counter table

This block keeps a table of small saturating counters, one per cache-reference signature, and uses it to decide how a newly filled cache line should be inserted. While a miss is being handled, the cache presents the signature of the incoming line on the prediction port. One cycle later the block answers "distant", meaning no reuse is expected, or "intermediate", meaning some reuse is expected. The replacement policy applies that answer when it inserts the line.

The cache also trains the table through two independent request channels. A hit on a line raises the counter of the signature stored with that line. An eviction of a line that was never reused lowers that line's counter. Only a counter of exactly zero produces a "distant" prediction.

The signature width and the counter width are parameters. Narrow counters learn faster and cost less storage. For a cache shared by several cores, the table can be one shared table, where the core number plays no part. It can instead be split into one private table per core, where the core number selects the table.

Top module: `sig_hit_table`

## Requirements
- R1: While rst_ni is low, pred_valid_o is 0. After reset every counter holds (2^(CTR_W-1))-1, so any signature that has not been trained predicts intermediate (pred_distant_o = 0).
- R2: A prediction request in cycle t gives pred_valid_o = 1 in cycle t+1, and pred_valid_o = 0 follows a cycle with no request. pred_distant_o = 1 exactly when the addressed counter is zero, and 0 for any positive value.
- R3: An increment raises the addressed counter by one and stops at 2^CTR_W-1. It never wraps to zero.
- R4: A decrement lowers the addressed counter by one and stops at zero. It never wraps to the maximum.
- R5: When a prediction and a training request address the same entry in the same cycle, the prediction reports the value from before the update, and the update still takes effect.
- R6: An increment and a decrement to the same entry in the same cycle cancel, and the counter is left unchanged.
- R7: An increment and a decrement to different entries in the same cycle are both applied.
- R8: With PER_CORE = 0, all cores share one table and the core inputs have no effect on which entry is used.
- R9: With PER_CORE = 1, each core has a private table selected by its core number. Training issued by one core does not change another core's prediction for the same signature.
- R10: With CTR_W = 2, counters reset to 1 and saturate at 3. A single decrement after reset gives a distant prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_valid_i | input | 1 | Prediction request |
| pred_sig_i | input | SIG_W | Signature of the incoming line |
| pred_core_i | input | CORE_W | Core issuing the prediction request |
| inc_valid_i | input | 1 | Increment request (line hit) |
| inc_sig_i | input | SIG_W | Signature to increment |
| inc_core_i | input | CORE_W | Core owning the increment |
| dec_valid_i | input | 1 | Decrement request (unreused line evicted) |
| dec_sig_i | input | SIG_W | Signature to decrement |
| dec_core_i | input | CORE_W | Core owning the decrement |
| pred_valid_o | output | 1 | Prediction result valid, one cycle after the request |
| pred_distant_o | output | 1 | 1 = distant (counter zero), 0 = intermediate |

## Verification
A prediction is due one clock edge after its request, and a training request changes its counter at the edge where it is presented. A prediction issued in the next cycle therefore already sees the new value. The bench drives every request on a falling edge, so one rising edge passes. It then samples pred_valid_o and pred_distant_o on the following falling edge, exactly one register stage after the request. Same-cycle collisions are checked by issuing the prediction together with the training request and reading the result one cycle later. A further prediction in the next cycle confirms what was written.

// File: rtl/shct_pkg.sv
package shct_pkg;
  typedef enum logic {SAT_UP, SAT_DN} sat_dir_e;

  // midpoint-minus-one: untrained signatures still predict reuse
  function automatic int unsigned init_level(input int unsigned w);
    return (32'd1 << (w - 1)) - 32'd1;
  endfunction
endpackage

// File: rtl/shct_index.sv
module shct_index #(
  parameter int SIG_W    = 10,
  parameter int CORE_W   = 2,
  parameter int IDX_W    = 10,
  parameter bit PER_CORE = 1'b0
) (
  input  logic [SIG_W-1:0]  sig_i,
  input  logic [CORE_W-1:0] core_i,
  output logic [IDX_W-1:0]  idx_o
);
  generate
    if (PER_CORE) begin : g_private
      assign idx_o = {core_i, sig_i};
    end else begin : g_shared
      logic unused_core;
      assign unused_core = ^core_i;
      assign idx_o = sig_i;
    end
  endgenerate
endmodule

// File: rtl/shct_sat.sv
module shct_sat
  import shct_pkg::*;
#(
  parameter int       CTR_W = 3,
  parameter sat_dir_e DIR   = SAT_UP
) (
  input  logic [CTR_W-1:0] cur_i,
  output logic [CTR_W-1:0] nxt_o
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  generate
    if (DIR == SAT_UP) begin : g_up
      assign nxt_o = (cur_i == CTR_MAX) ? cur_i : cur_i + CTR_W'(1);
    end else begin : g_dn
      assign nxt_o = (cur_i == '0) ? cur_i : cur_i - CTR_W'(1);
    end
  endgenerate
endmodule

// File: rtl/shct_store.sv
module shct_store #(
  parameter int               IDX_W = 10,
  parameter int               CTR_W = 3,
  parameter logic [CTR_W-1:0] INIT  = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] p_idx_i,
  input  logic [IDX_W-1:0] a_idx_i,
  input  logic [IDX_W-1:0] b_idx_i,
  output logic [CTR_W-1:0] p_ctr_o,
  output logic [CTR_W-1:0] a_ctr_o,
  output logic [CTR_W-1:0] b_ctr_o,
  input  logic             a_we_i,
  input  logic [CTR_W-1:0] a_d_i,
  input  logic             b_we_i,
  input  logic [CTR_W-1:0] b_d_i
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [CTR_W-1:0] ctr_q [ENTRIES];

  assign p_ctr_o = ctr_q[p_idx_i];
  assign a_ctr_o = ctr_q[a_idx_i];
  assign b_ctr_o = ctr_q[b_idx_i];

  // callers guarantee a_idx != b_idx when both write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= INIT;
    end else begin
      if (a_we_i) ctr_q[a_idx_i] <= a_d_i;
      if (b_we_i) ctr_q[b_idx_i] <= b_d_i;
    end
  end
endmodule

// File: rtl/sig_hit_table.sv
module sig_hit_table
  import shct_pkg::*;
#(
  parameter int SIG_W     = 10,
  parameter int CTR_W     = 3,
  parameter int NUM_CORES = 4,
  parameter bit PER_CORE  = 1'b0,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pred_valid_i,
  input  logic [SIG_W-1:0]  pred_sig_i,
  input  logic [CORE_W-1:0] pred_core_i,
  input  logic              inc_valid_i,
  input  logic [SIG_W-1:0]  inc_sig_i,
  input  logic [CORE_W-1:0] inc_core_i,
  input  logic              dec_valid_i,
  input  logic [SIG_W-1:0]  dec_sig_i,
  input  logic [CORE_W-1:0] dec_core_i,
  output logic              pred_valid_o,
  output logic              pred_distant_o
);
  localparam int               IDX_W    = SIG_W + (PER_CORE ? CORE_W : 0);
  localparam logic [CTR_W-1:0] CTR_INIT = CTR_W'(init_level(CTR_W));

  logic [IDX_W-1:0] pred_idx, inc_idx, dec_idx;
  logic [CTR_W-1:0] pred_ctr, inc_cur, dec_cur, inc_nxt, dec_nxt;
  logic             collide, inc_we, dec_we;
  logic             pred_valid_q, pred_distant_q;

  shct_index #(.SIG_W(SIG_W), .CORE_W(CORE_W), .IDX_W(IDX_W), .PER_CORE(PER_CORE))
    u_idx_pred (.sig_i(pred_sig_i), .core_i(pred_core_i), .idx_o(pred_idx));
  shct_index #(.SIG_W(SIG_W), .CORE_W(CORE_W), .IDX_W(IDX_W), .PER_CORE(PER_CORE))
    u_idx_inc  (.sig_i(inc_sig_i),  .core_i(inc_core_i),  .idx_o(inc_idx));
  shct_index #(.SIG_W(SIG_W), .CORE_W(CORE_W), .IDX_W(IDX_W), .PER_CORE(PER_CORE))
    u_idx_dec  (.sig_i(dec_sig_i),  .core_i(dec_core_i),  .idx_o(dec_idx));

  shct_sat #(.CTR_W(CTR_W), .DIR(SAT_UP)) u_sat_up (.cur_i(inc_cur), .nxt_o(inc_nxt));
  shct_sat #(.CTR_W(CTR_W), .DIR(SAT_DN)) u_sat_dn (.cur_i(dec_cur), .nxt_o(dec_nxt));

  // opposite requests on one entry cancel
  assign collide = inc_valid_i && dec_valid_i && (inc_idx == dec_idx);
  assign inc_we  = inc_valid_i && !collide;
  assign dec_we  = dec_valid_i && !collide;

  shct_store #(.IDX_W(IDX_W), .CTR_W(CTR_W), .INIT(CTR_INIT)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .p_idx_i (pred_idx),
    .a_idx_i (inc_idx),
    .b_idx_i (dec_idx),
    .p_ctr_o (pred_ctr),
    .a_ctr_o (inc_cur),
    .b_ctr_o (dec_cur),
    .a_we_i  (inc_we),
    .a_d_i   (inc_nxt),
    .b_we_i  (dec_we),
    .b_d_i   (dec_nxt)
  );

  // read samples pre-update contents on the same edge as the write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_valid_q   <= 1'b0;
      pred_distant_q <= 1'b0;
    end else begin
      pred_valid_q   <= pred_valid_i;
      pred_distant_q <= pred_valid_i && (pred_ctr == '0);
    end
  end

  assign pred_valid_o   = pred_valid_q;
  assign pred_distant_o = pred_distant_q;
endmodule

// File: rtl/sig_hit_table_chk.sv
module sig_hit_table_chk #(
  parameter int CTR_W = 3,
  parameter int IDX_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pred_valid_i,
  input logic             pred_valid_o,
  input logic             pred_distant_o,
  input logic [CTR_W-1:0] pred_ctr_i,
  input logic             inc_valid_i,
  input logic             dec_valid_i,
  input logic [IDX_W-1:0] inc_idx_i,
  input logic [IDX_W-1:0] dec_idx_i,
  input logic             inc_we_i,
  input logic             dec_we_i,
  input logic [CTR_W-1:0] inc_nxt_i,
  input logic [CTR_W-1:0] dec_nxt_i
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  always @(posedge clk_i) begin
    if (!rst_ni) a_r1_quiet_in_reset: assert (!pred_valid_o);
  end

  a_r2_valid_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i |=> pred_valid_o);

  a_r2_idle_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_valid_i |=> !pred_valid_o);

  a_r2_zero_is_distant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_i |=> (pred_distant_o == ($past(pred_ctr_i) == '0)));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_we_i |-> (inc_nxt_i != '0));

  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_we_i |-> (dec_nxt_i != CTR_MAX));

  a_r6_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_valid_i && dec_valid_i && (inc_idx_i == dec_idx_i)) |-> (!inc_we_i && !dec_we_i));
endmodule

bind sig_hit_table sig_hit_table_chk #(.CTR_W(CTR_W), .IDX_W(IDX_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .pred_valid_i   (pred_valid_i),
  .pred_valid_o   (pred_valid_o),
  .pred_distant_o (pred_distant_o),
  .pred_ctr_i     (pred_ctr),
  .inc_valid_i    (inc_valid_i),
  .dec_valid_i    (dec_valid_i),
  .inc_idx_i      (inc_idx),
  .dec_idx_i      (dec_idx),
  .inc_we_i       (inc_we),
  .dec_we_i       (dec_we),
  .inc_nxt_i      (inc_nxt),
  .dec_nxt_i      (dec_nxt)
);

// File: tb/tb_sig_hit_table.sv
`timescale 1ns/1ps
module tb_sig_hit_table;
  localparam int SIG_W   = 10;
  localparam int P_SIG_W = 6;

  localparam logic [1:0] OP_NOP = 2'd0, OP_PRD = 2'd1, OP_INC = 2'd2, OP_DEC = 2'd3;

  typedef struct packed {
    logic [1:0]       op;
    logic [SIG_W-1:0] sig;
    logic             exp;
    logic [1:0]       req;  // 0:R1 1:R2 2:R3 3:R4
  } vec_t;

  localparam int NVEC = 27;
  localparam vec_t VEC [NVEC] = '{
    '{OP_PRD, 10'd5, 1'b0, 2'd0},
    '{OP_DEC, 10'd5, 1'b0, 2'd1}, '{OP_DEC, 10'd5, 1'b0, 2'd1},
    '{OP_PRD, 10'd5, 1'b0, 2'd1},
    '{OP_DEC, 10'd5, 1'b0, 2'd1},
    '{OP_PRD, 10'd5, 1'b1, 2'd1},
    '{OP_DEC, 10'd5, 1'b0, 2'd3}, '{OP_DEC, 10'd5, 1'b0, 2'd3},
    '{OP_INC, 10'd5, 1'b0, 2'd3},
    '{OP_PRD, 10'd5, 1'b0, 2'd3},
    '{OP_DEC, 10'd5, 1'b0, 2'd3},
    '{OP_PRD, 10'd5, 1'b1, 2'd3},
    '{OP_INC, 10'd9, 1'b0, 2'd2}, '{OP_INC, 10'd9, 1'b0, 2'd2},
    '{OP_INC, 10'd9, 1'b0, 2'd2}, '{OP_INC, 10'd9, 1'b0, 2'd2},
    '{OP_INC, 10'd9, 1'b0, 2'd2}, '{OP_INC, 10'd9, 1'b0, 2'd2},
    '{OP_DEC, 10'd9, 1'b0, 2'd2}, '{OP_DEC, 10'd9, 1'b0, 2'd2},
    '{OP_DEC, 10'd9, 1'b0, 2'd2}, '{OP_DEC, 10'd9, 1'b0, 2'd2},
    '{OP_DEC, 10'd9, 1'b0, 2'd2}, '{OP_DEC, 10'd9, 1'b0, 2'd2},
    '{OP_PRD, 10'd9, 1'b0, 2'd2},
    '{OP_DEC, 10'd9, 1'b0, 2'd2},
    '{OP_PRD, 10'd9, 1'b1, 2'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             pv, iv, dv;
  logic [SIG_W-1:0] ps, is_, ds;
  logic [1:0]       pc, ic, dc;
  logic             pvo, pdo;

  logic               qpv, qiv, qdv;
  logic [P_SIG_W-1:0] qps, qis, qds;
  logic [1:0]         qpc, qic, qdc;
  logic               qpvo, qpdo;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  sig_hit_table #(.SIG_W(SIG_W), .CTR_W(3), .NUM_CORES(4), .PER_CORE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_valid_i(pv), .pred_sig_i(ps), .pred_core_i(pc),
    .inc_valid_i(iv), .inc_sig_i(is_), .inc_core_i(ic),
    .dec_valid_i(dv), .dec_sig_i(ds), .dec_core_i(dc),
    .pred_valid_o(pvo), .pred_distant_o(pdo)
  );

  sig_hit_table #(.SIG_W(P_SIG_W), .CTR_W(2), .NUM_CORES(4), .PER_CORE(1'b1)) dut_priv (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_valid_i(qpv), .pred_sig_i(qps), .pred_core_i(qpc),
    .inc_valid_i(qiv), .inc_sig_i(qis), .inc_core_i(qic),
    .dec_valid_i(qdv), .dec_sig_i(qds), .dec_core_i(qdc),
    .pred_valid_o(qpvo), .pred_distant_o(qpdo)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive on negedge, one rising edge, return on next negedge
  task automatic cyc(input logic p, input logic [SIG_W-1:0] psig, input logic [1:0] pcore,
                     input logic i, input logic [SIG_W-1:0] isig,
                     input logic d, input logic [SIG_W-1:0] dsig, input logic [1:0] tcore);
    pv = p; ps = psig; pc = pcore;
    iv = i; is_ = isig; ic = tcore;
    dv = d; ds = dsig; dc = tcore;
    @(negedge clk);
    pv = 1'b0; iv = 1'b0; dv = 1'b0;
  endtask

  task automatic qcyc(input logic p, input logic [P_SIG_W-1:0] psig, input logic [1:0] pcore,
                      input logic i, input logic d, input logic [P_SIG_W-1:0] tsig,
                      input logic [1:0] tcore);
    qpv = p; qps = psig; qpc = pcore;
    qiv = i; qis = tsig; qic = tcore;
    qdv = d; qds = tsig; qdc = tcore;
    @(negedge clk);
    qpv = 1'b0; qiv = 1'b0; qdv = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    pv = 0; iv = 0; dv = 0; ps = '0; is_ = '0; ds = '0; pc = '0; ic = '0; dc = '0;
    qpv = 0; qiv = 0; qdv = 0; qps = '0; qis = '0; qds = '0; qpc = '0; qic = '0; qdc = '0;
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", pvo, 1'b0);
    chk("R1 priv valid low in reset", qpvo, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: untrained far signature predicts intermediate
    cyc(1'b1, 10'd1023, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R1 valid after pred", pvo, 1'b1);
    chk("R1 untrained intermediate", pdo, 1'b0);
    // R2: idle cycle gives no valid
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R2 idle no valid", pvo, 1'b0);

    // vector walk: R1..R4
    for (int k = 0; k < NVEC; k++) begin
      cyc(VEC[k].op == OP_PRD, VEC[k].sig, 2'd0,
          VEC[k].op == OP_INC, VEC[k].sig,
          VEC[k].op == OP_DEC, VEC[k].sig, 2'd0);
      if (VEC[k].op == OP_PRD) begin
        case (VEC[k].req)
          2'd0:    chk("R1 vector", pdo, VEC[k].exp);
          2'd1:    chk("R2 vector", pdo, VEC[k].exp);
          2'd2:    chk("R3 vector", pdo, VEC[k].exp);
          default: chk("R4 vector", pdo, VEC[k].exp);
        endcase
        chk("R2 vector valid", pvo, 1'b1);
      end
    end

    // R5: sig 20 to 1, then predict while decrementing
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd20, 2'd0);
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd20, 2'd0);
    cyc(1'b1, 10'd20, 2'd0, 1'b0, '0, 1'b1, 10'd20, 2'd0);
    chk("R5 pre-update value", pdo, 1'b0);
    cyc(1'b1, 10'd20, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R5 update applied", pdo, 1'b1);

    // R6: sig 30 to 1, then inc+dec together
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd30, 2'd0);
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd30, 2'd0);
    cyc(1'b0, '0, 2'd0, 1'b1, 10'd30, 1'b1, 10'd30, 2'd0);
    cyc(1'b1, 10'd30, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R6 cancel not lowered", pdo, 1'b0);
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd30, 2'd0);
    cyc(1'b1, 10'd30, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R6 cancel not raised", pdo, 1'b1);

    // R7: sig 41 to 1; inc 40 and dec 41 together
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd41, 2'd0);
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd41, 2'd0);
    cyc(1'b0, '0, 2'd0, 1'b1, 10'd40, 1'b1, 10'd41, 2'd0);
    cyc(1'b1, 10'd41, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R7 dec applied", pdo, 1'b1);
    for (int k = 0; k < 3; k++) cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd40, 2'd0);
    cyc(1'b1, 10'd40, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R7 inc applied", pdo, 1'b0);
    cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd40, 2'd0);
    cyc(1'b1, 10'd40, 2'd0, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R7 inc reached 4", pdo, 1'b1);

    // R8: shared table, train as core 0, predict as core 3
    for (int k = 0; k < 3; k++) cyc(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 10'd50, 2'd0);
    cyc(1'b1, 10'd50, 2'd3, 1'b0, '0, 1'b0, '0, 2'd0);
    chk("R8 core ignored", pdo, 1'b1);

    // R9 / R10: private 2-bit tables
    qcyc(1'b0, '0, 2'd0, 1'b0, 1'b1, 6'd3, 2'd1);
    qcyc(1'b1, 6'd3, 2'd1, 1'b0, 1'b0, '0, 2'd0);
    chk("R10 one dec reaches zero", qpdo, 1'b1);
    chk("R9 priv valid", qpvo, 1'b1);
    qcyc(1'b1, 6'd3, 2'd0, 1'b0, 1'b0, '0, 2'd0);
    chk("R9 other core untouched", qpdo, 1'b0);
    for (int k = 0; k < 3; k++) qcyc(1'b0, '0, 2'd0, 1'b1, 1'b0, 6'd4, 2'd2);
    qcyc(1'b0, '0, 2'd0, 1'b0, 1'b1, 6'd4, 2'd2);
    qcyc(1'b0, '0, 2'd0, 1'b0, 1'b1, 6'd4, 2'd2);
    qcyc(1'b1, 6'd4, 2'd2, 1'b0, 1'b0, '0, 2'd0);
    chk("R10 saturates at 3", qpdo, 1'b0);
    qcyc(1'b0, '0, 2'd0, 1'b0, 1'b1, 6'd4, 2'd2);
    qcyc(1'b1, 6'd4, 2'd2, 1'b0, 1'b0, '0, 2'd0);
    chk("R10 reaches zero from 3", qpdo, 1'b1);

    finish_run();
  end
endmodule